// File: doc/BRIEF.md
# Staging Mailbox Register Target

This block is the device side of a four-register staging mailbox on a simple register bus. The host streams a request object into it one 32-bit word at a time through a write-data register. The object is a 64-bit mailbox header, then a 64-bit command, then the data words of one image chunk. The host then sets the go bit in the control register. The target checks the request. If the request is good, it advances its record of how much of the image it holds and raises ready. If it is bad, it raises error instead.

After a good request, the host drains a four-word response through the read-data register. Each word is read and then acknowledged by a write to that same register. The response names the next byte offset of the image that the target wants. When the whole image has arrived, the offset field reads all ones instead. An abort bit in the control register throws away any request or response in flight and restarts the image from offset zero.

The chunk payload is counted but not stored. The image length and the vendor identifier are parameters.

Top module: `stg_mbox_target`

## Requirements
- R1: After reset, status, read-data and control all read 0. The target expects image offset 0.
- R2: Registers are decoded at byte addresses 0x0 (control), 0x4 (status), 0x8 (write-data) and 0xC (read-data). Control and write-data read as 0. Status bit 31 is ready and status bit 2 is error. All other status bits read 0.
- R3: A write of control with bit 31 (go) set and bit 0 clear evaluates the words pushed so far. A valid request sets status to 0x80000000 from the following cycle.
- R4: While ready, read-data presents four words in this order: header low = vendor in bits 15:0 and 0x0B in bits 23:16; header high = 4; next offset; status word. Any write to 0xC advances to the next word. After the fourth word, read-data reads 0.
- R5: A valid request is header low (vendor in 15:0, 0x0B in 23:16, 0 in 31:24), header high (total words pushed, headers included), command low = 3, command high = 0, then N data words. It advances the expected offset by 4*N bytes, and the response reports the new offset.
- R6: Once the offset reaches IMAGE_BYTES, the response offset is 0xFFFFFFFF and the status word is 0x1. Before that, the status word is 0x3 (bit 0 success, bit 1 in progress). Later valid requests keep returning the sentinel.
- R7: A request whose header size field differs from the number of words pushed sets status to 0x00000004. It leaves the offset unchanged and yields no response words.
- R8: A request whose command low word is not 3, or whose command high word is not 0, sets status to 0x00000004.
- R9: A wrong vendor, an object type other than 0x0B, a nonzero byte 31:24 in header low, or fewer than four words pushed sets status to 0x00000004.
- R10: A control write with bit 0 (abort) set clears status, the read pointer and any partial request in one cycle, and resets the expected offset to 0. Abort takes precedence over go in the same write.
- R11: While status holds ready or error, go has no effect. Writes to the status register never change it.
- R12: A write to write-data while status holds ready or error clears status and starts a new request with that word as header low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wr | input | 1 | Write enable, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The assertions assume the host performs at most one register write per clock, and that it pushes no more words than the size counter can hold. The directed bench issues one bus write per call of its write task, spaced a full clock apart. Its largest request is 12 words, well below the counter's saturation point. The in-design checks can therefore rely on go, abort, push and acknowledge never arriving in the same cycle.

// File: rtl/stg_mbox_pkg.sv
package stg_mbox_pkg;

    localparam int unsigned DW = 32;

    // control and status bit positions
    localparam int unsigned CTRL_ABORT_BIT = 0;
    localparam int unsigned CTRL_GO_BIT    = 31;
    localparam int unsigned STAT_READY_BIT = 31;
    localparam int unsigned STAT_ERR_BIT   = 2;

    localparam logic [7:0]    OBJ_KIND    = 8'h0B;
    localparam logic [DW-1:0] CMD_LOAD    = 32'd3;
    localparam logic [DW-1:0] RESP_LEN_DW = 32'd4;
    localparam logic [DW-1:0] END_MARK    = 32'hFFFF_FFFF;
    localparam int unsigned   HDR_WORDS   = 4;
    localparam int unsigned   RESP_WORDS  = 4;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_WDATA = 2'd2,
        SEL_RDATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [31:0] size_dw;
        logic [7:0]  rsvd;
        logic [7:0]  kind;
        logic [15:0] vendor;
    } mbox_hdr_t;

    typedef struct packed {
        logic ready;
        logic err;
    } mbox_stat_t;

    function automatic logic [DW-1:0] stat_word(mbox_stat_t s);
        logic [DW-1:0] w;
        w = '0;
        w[STAT_READY_BIT] = s.ready;
        w[STAT_ERR_BIT]   = s.err;
        return w;
    endfunction

    // one word of the response object
    function automatic logic [DW-1:0] resp_word(logic [1:0] idx, logic [15:0] vendor,
                                                logic [DW-1:0] next_off, logic in_prog);
        unique case (idx)
            2'd0:    return {8'h00, OBJ_KIND, vendor};
            2'd1:    return RESP_LEN_DW;
            2'd2:    return next_off;
            default: return {30'd0, in_prog, 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/stg_mbox_req_parser.sv
module stg_mbox_req_parser
    import stg_mbox_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1D5A,
    parameter int unsigned CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic             push_first,
    input  logic [DW-1:0]    wdata,
    output logic             req_ok,
    output logic [CNT_W-1:0] chunk_dw
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] HDR_CNT = CNT_W'(HDR_WORDS);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic [DW-1:0]    words [HDR_WORDS];
    mbox_hdr_t        hdr;

    assign idx = push_first ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (push) begin
            if (push_first)          cnt <= CNT_W'(1);
            else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (rst || clear)
                words[g] <= '0;
            else if (push && idx == CNT_W'(g))
                words[g] <= wdata;
        end
    end

    assign hdr = mbox_hdr_t'({words[1], words[0]});

    always_comb begin
        req_ok = (cnt >= HDR_CNT)
              && (hdr.vendor == VENDOR_ID)
              && (hdr.kind == OBJ_KIND)
              && (hdr.rsvd == 8'h00)
              && (hdr.size_dw == 32'(cnt))
              && (words[2] == CMD_LOAD)
              && (words[3] == '0);
        chunk_dw = cnt - HDR_CNT;
    end

    // R12: a push after completion restarts the word count
    a_r12_restart_count: assert property (@(posedge clk) disable iff (rst)
        (push && push_first && !clear) |=> (cnt == CNT_W'(1)));

    // R10: abort discards any partial request
    a_r10_clear_count: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

endmodule

// File: rtl/stg_mbox_chunk_sink.sv
module stg_mbox_chunk_sink
    import stg_mbox_pkg::*;
#(
    parameter int unsigned IMAGE_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          accept,
    input  logic [DW-1:0] chunk_bytes,
    output logic [DW-1:0] next_off,
    output logic          in_prog
);
    localparam logic [DW:0]   LIMIT_W = (DW+1)'(IMAGE_BYTES);
    localparam logic [DW-1:0] LIMIT   = DW'(IMAGE_BYTES);

    logic [DW-1:0] offset;
    logic [DW:0]   sum;

    assign sum = {1'b0, offset} + {1'b0, chunk_bytes};

    always_ff @(posedge clk) begin
        if (rst || clear)
            offset <= '0;
        else if (accept)
            offset <= (sum >= LIMIT_W) ? LIMIT : sum[DW-1:0];
    end

    assign in_prog  = (offset < LIMIT);
    assign next_off = in_prog ? offset : END_MARK;

    // R6: the tracked offset never passes the image length
    a_r6_offset_bounded: assert property (@(posedge clk) disable iff (rst)
        offset <= LIMIT);

    // R5: without abort the offset never moves backwards
    a_r5_offset_monotone: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (offset >= $past(offset)));

    // R7: no accepted request, no offset change
    a_r7_offset_hold: assert property (@(posedge clk) disable iff (rst)
        (!clear && !accept) |=> $stable(offset));

endmodule

// File: rtl/stg_mbox_resp_queue.sv
module stg_mbox_resp_queue
    import stg_mbox_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1D5A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          set_ready,
    input  logic          set_err,
    input  logic          ack,
    input  logic [DW-1:0] next_off,
    input  logic          in_prog,
    output mbox_stat_t    stat,
    output logic [DW-1:0] cur_word
);
    localparam int unsigned PTR_W = $clog2(RESP_WORDS + 1);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(RESP_WORDS);

    logic [PTR_W-1:0] rptr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stat <= '0;
            rptr <= '0;
        end else begin
            if (set_ready)      stat <= '{ready: 1'b1, err: 1'b0};
            else if (set_err)   stat <= '{ready: 1'b0, err: 1'b1};
            if (ack && stat.ready && rptr != PTR_END)
                rptr <= rptr + 1'b1;
        end
    end

    always_comb begin
        if (stat.ready && rptr != PTR_END)
            cur_word = resp_word(rptr[1:0], VENDOR_ID, next_off, in_prog);
        else
            cur_word = '0;
    end

    // R3: ready and error are exclusive
    a_r3_stat_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(stat.ready && stat.err));

    // R4: the read pointer stops after the last response word
    a_r4_ptr_bounded: assert property (@(posedge clk) disable iff (rst)
        rptr <= PTR_END);

    // R4: each acknowledge advances exactly one word
    a_r4_ack_step: assert property (@(posedge clk) disable iff (rst)
        (ack && stat.ready && rptr != PTR_END && !clear) |=> (rptr == $past(rptr) + 1'b1));

    // R10: abort or restart empties status and pointer
    a_r10_clear_status: assert property (@(posedge clk) disable iff (rst)
        clear |=> (stat == '0 && rptr == '0));

endmodule

// File: rtl/stg_mbox_target.sv
module stg_mbox_target
    import stg_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter logic [15:0] VENDOR_ID   = 16'h1D5A,
    parameter int unsigned IMAGE_BYTES = 64,
    parameter int unsigned CNT_W       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(4'h8);
    localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(4'hC);

    logic             hit_ctrl, hit_stat, hit_wdata, hit_rdata;
    logic             abort, go, go_eval, push, push_first, ack, clear_all;
    logic             req_ok;
    logic [CNT_W-1:0] chunk_dw;
    logic [DW-1:0]    chunk_bytes;
    logic [DW-1:0]    next_off;
    logic             in_prog;
    mbox_stat_t       stat;
    logic [DW-1:0]    cur_word;

    assign hit_ctrl  = (reg_addr == A_CTRL);
    assign hit_stat  = (reg_addr == A_STAT);
    assign hit_wdata = (reg_addr == A_WDATA);
    assign hit_rdata = (reg_addr == A_RDATA);

    assign abort      = reg_wr && hit_ctrl && reg_wdata[CTRL_ABORT_BIT];
    assign go         = reg_wr && hit_ctrl && reg_wdata[CTRL_GO_BIT] && !reg_wdata[CTRL_ABORT_BIT];
    assign go_eval    = go && !stat.ready && !stat.err;
    assign push       = reg_wr && hit_wdata;
    assign push_first = stat.ready || stat.err;
    assign ack        = reg_wr && hit_rdata;
    assign clear_all  = abort || (push && push_first);

    assign chunk_bytes = DW'(chunk_dw) << 2;

    stg_mbox_req_parser #(
        .VENDOR_ID (VENDOR_ID),
        .CNT_W     (CNT_W)
    ) parser_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (abort),
        .push       (push),
        .push_first (push_first),
        .wdata      (reg_wdata),
        .req_ok     (req_ok),
        .chunk_dw   (chunk_dw)
    );

    stg_mbox_chunk_sink #(
        .IMAGE_BYTES (IMAGE_BYTES)
    ) sink_i (
        .clk         (clk),
        .rst         (rst),
        .clear       (abort),
        .accept      (go_eval && req_ok),
        .chunk_bytes (chunk_bytes),
        .next_off    (next_off),
        .in_prog     (in_prog)
    );

    stg_mbox_resp_queue #(
        .VENDOR_ID (VENDOR_ID)
    ) resp_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear_all),
        .set_ready (go_eval && req_ok),
        .set_err   (go_eval && !req_ok),
        .ack       (ack),
        .next_off  (next_off),
        .in_prog   (in_prog),
        .stat      (stat),
        .cur_word  (cur_word)
    );

    always_comb begin
        if (hit_stat)       reg_rdata = stat_word(stat);
        else if (hit_rdata) reg_rdata = cur_word;
        else                reg_rdata = '0;
    end

    // R11: go while a result is pending leaves status unchanged
    a_r11_go_ignored: assert property (@(posedge clk) disable iff (rst)
        (go && (stat.ready || stat.err)) |=> $stable(stat));

    // R3: a go on a clean status always produces a result
    a_r3_go_result: assert property (@(posedge clk) disable iff (rst)
        go_eval |=> (stat.ready || stat.err));

endmodule

// File: tb/stg_mbox_target_tb_top.sv
module stg_mbox_target_tb_top;

    localparam logic [15:0] VID   = 16'h1D5A;
    localparam int unsigned IMG   = 64;
    localparam logic [31:0] HLO   = {8'h00, 8'h0B, VID};
    localparam logic [31:0] RDY   = 32'h8000_0000;
    localparam logic [31:0] ERR   = 32'h0000_0004;
    localparam logic [31:0] ENDM  = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    stg_mbox_target #(
        .ADDR_W      (4),
        .VENDOR_ID   (VID),
        .IMAGE_BYTES (IMG),
        .CNT_W       (12)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_req(input logic [15:0] vid, input logic [7:0] kind,
                            input int size_adj, input logic [31:0] cmd_lo,
                            input logic [31:0] cmd_hi, input int ndata, input bit go);
        bus_write(4'h8, {8'h00, kind, vid});
        bus_write(4'h8, 32'(4 + ndata + size_adj));
        bus_write(4'h8, cmd_lo);
        bus_write(4'h8, cmd_hi);
        for (int i = 0; i < ndata; i++) bus_write(4'h8, 32'hA500_0000 + 32'(i));
        if (go) bus_write(4'h0, 32'h8000_0000);
    endtask

    task automatic expect_resp(input string tag, input logic [31:0] off, input logic [31:0] st);
        logic [31:0] d;
        bus_read(4'hC, d); check({tag, " R4 hdr lo"}, d, HLO);
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, d); check({tag, " R4 hdr hi"}, d, 32'd4);
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, d); check({tag, " R5 offset"}, d, off);
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, d); check({tag, " R6 status word"}, d, st);
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, d); check({tag, " R4 past end"}, d, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(4'h4, d); check("R1 status at reset", d, 32'h0);
        bus_read(4'hC, d); check("R1 rdata at reset", d, 32'h0);
        bus_read(4'h0, d); check("R2 control reads 0", d, 32'h0);
        bus_read(4'h8, d); check("R2 wdata reads 0", d, 32'h0);
    endtask

    task automatic t_first_chunk;
        logic [31:0] d;
        send_req(VID, 8'h0B, 0, 32'd3, 32'd0, 4, 1'b1);
        bus_read(4'h4, d); check("R3 ready after go", d, RDY);
        expect_resp("first", 32'd16, 32'h3);
    endtask

    task automatic t_size_mismatch;
        logic [31:0] d;
        send_req(VID, 8'h0B, 1, 32'd3, 32'd0, 4, 1'b1);
        bus_read(4'h4, d); check("R7 size mismatch error", d, ERR);
        bus_read(4'hC, d); check("R7 no response words", d, 32'h0);
    endtask

    task automatic t_go_ignored;
        logic [31:0] d;
        bus_write(4'h0, 32'h8000_0000);
        bus_read(4'h4, d); check("R11 go while error", d, ERR);
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, d); check("R11 status write ignored", d, ERR);
    endtask

    task automatic t_bad_cmd;
        logic [31:0] d;
        bus_write(4'h8, HLO);
        bus_read(4'h4, d); check("R12 push clears status", d, 32'h0);
        bus_write(4'h8, 32'd5);
        bus_write(4'h8, 32'd2);
        bus_write(4'h8, 32'd0);
        bus_write(4'h8, 32'h1);
        bus_write(4'h0, 32'h8000_0000);
        bus_read(4'h4, d); check("R8 cmd low not 3", d, ERR);
        send_req(VID, 8'h0B, 0, 32'd3, 32'd1, 1, 1'b1);
        bus_read(4'h4, d); check("R8 cmd high nonzero", d, ERR);
    endtask

    task automatic t_bad_hdr;
        logic [31:0] d;
        send_req(16'h1234, 8'h0B, 0, 32'd3, 32'd0, 2, 1'b1);
        bus_read(4'h4, d); check("R9 wrong vendor", d, ERR);
        send_req(VID, 8'h0C, 0, 32'd3, 32'd0, 2, 1'b1);
        bus_read(4'h4, d); check("R9 wrong type", d, ERR);
        bus_write(4'h8, 32'h0100_0000 | HLO);
        bus_write(4'h8, 32'd4);
        bus_write(4'h8, 32'd3);
        bus_write(4'h8, 32'd0);
        bus_write(4'h0, 32'h8000_0000);
        bus_read(4'h4, d); check("R9 reserved byte set", d, ERR);
        bus_write(4'h8, HLO);
        bus_write(4'h8, 32'd3);
        bus_write(4'h8, 32'd3);
        bus_write(4'h0, 32'h8000_0000);
        bus_read(4'h4, d); check("R9 short request", d, ERR);
    endtask

    task automatic t_second_chunk;
        logic [31:0] d;
        send_req(VID, 8'h0B, 0, 32'd3, 32'd0, 8, 1'b1);
        bus_read(4'h4, d); check("R7 errors kept offset, ready", d, RDY);
        expect_resp("second", 32'd48, 32'h3);
    endtask

    task automatic t_finish;
        logic [31:0] d;
        send_req(VID, 8'h0B, 0, 32'd3, 32'd0, 4, 1'b1);
        bus_read(4'h4, d); check("R6 final ready", d, RDY);
        expect_resp("final", ENDM, 32'h1);
        send_req(VID, 8'h0B, 0, 32'd3, 32'd0, 2, 1'b1);
        expect_resp("after end", ENDM, 32'h1);
    endtask

    task automatic t_abort;
        logic [31:0] d;
        bus_write(4'h8, HLO);
        bus_write(4'h8, 32'd6);
        bus_write(4'h0, 32'h0000_0001);
        bus_read(4'h4, d); check("R10 abort clears status", d, 32'h0);
        send_req(VID, 8'h0B, 0, 32'd3, 32'd0, 2, 1'b1);
        bus_read(4'h4, d); check("R10 clean request after abort", d, RDY);
        bus_read(4'hC, d); check("R10 rdata first word", d, HLO);
        bus_write(4'hC, 32'h0);
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, d); check("R10 offset restarted", d, 32'd8);
        bus_write(4'h0, 32'h0000_0001);
        bus_read(4'h4, d); check("R10 abort while ready", d, 32'h0);
        bus_read(4'hC, d); check("R10 rdata cleared", d, 32'h0);
        send_req(VID, 8'h0B, 0, 32'd3, 32'd0, 1, 1'b0);
        bus_write(4'h0, 32'h8000_0001);
        bus_read(4'h4, d); check("R10 abort beats go", d, 32'h0);
        send_req(VID, 8'h0B, 0, 32'd3, 32'd0, 1, 1'b1);
        expect_resp("post abort", 32'd4, 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_chunk();
        t_size_mismatch();
        t_go_ignored();
        t_bad_cmd();
        t_bad_hdr();
        t_second_chunk();
        t_finish();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule